// File: doc/BRIEF.md
# Lockable Clock Failure Detection Controller

This block watches one of three clocks for missing edges and raises a sticky failure flag, plus an interrupt request, when the selected clock stops. Each watched clock is resynchronized into the reference clock domain. A counter measures how long it has been since the last rising edge of the selected clock. When the counter reaches a programmable timeout, the block declares a failure.

Software controls the block through a byte-wide register bus. A control register at offset 0x02 holds the source select, a test bit that forces a failure, and the enable bit. A write to the control register is accepted only shortly after a key byte has been written to the protect register. A status register holds the write-one-to-clear failure flag.

Once monitoring is enabled with the failure interrupt enabled and routed as non-maskable, the source select and the enable bit freeze. They stay frozen until the next reset.

Top module: `cfd_ctrl`

## Requirements
- R1: After reset the control register (offset 0x02) reads 0x00, and fail_o, irq_o and nmi_o are 0.
- R2: A write to offset 0x02 takes effect only if it comes 1 to 4 cycles after the key 0xA5 has been written to offset 0x00. An accepted control write closes the window. Any other control write is ignored.
- R3: Bits 7:4 of the control register read 0 and ignore writes. A write carrying source code 3 leaves the source field unchanged.
- R4: Control register layout: bits 3:2 hold the source (0 = main clock, 1 = high-frequency oscillator, 2 = 32 kHz oscillator), bit 1 is the test bit and bit 0 is enable. Accepted writes read back through the same layout.
- R5: With enable set, fail_o rises once the selected clock shows no rising edge for TIMEOUT reference cycles (default 64). fail_o stays 0 while that clock keeps running.
- R6: With enable clear, a stopped clock never sets the failure flag.
- R7: Setting the test bit drives fail_o to 1. Writing 0 to the test bit removes that forced failure. Clearing the status flag does not remove it.
- R8: A detected failure is sticky. It stays set after the clock resumes until 1 is written to bit 0 of the status register at offset 0x01. That bit reads back fail_o.
- R9: While fail_o is 1 and fail_int_en_i is 1, irq_o is asserted if int_type_i is 0 and nmi_o if int_type_i is 1. The two are never asserted together.
- R10: When enable, fail_int_en_i and int_type_i are all 1, the source field and the enable bit ignore writes until reset, even after those inputs drop. The test bit stays writable.
- R11: Changing the source field or setting the enable bit restarts the timeout count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Active-low asynchronous system reset |
| we_i | input | 1 | Register write strobe |
| addr_i | input | 4 | Register offset |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for addr_i |
| mclk_i | input | 3 | Monitored clocks, indexed by source code |
| fail_int_en_i | input | 1 | Failure interrupt enable |
| int_type_i | input | 1 | 0: normal interrupt, 1: non-maskable |
| fail_o | output | 1 | Failure flag or forced test failure |
| irq_o | output | 1 | Normal interrupt request |
| nmi_o | output | 1 | Non-maskable interrupt request |

## Verification
The bench probes the protection window at its edges, with writes 4 and 5 cycles after the key. A design with an off-by-one window would either lose a legal write or accept a late one. It stops a clock and samples well inside and well beyond the timeout. It then switches between two stopped sources at a point where the combined silence already exceeds the timeout, so a design that does not restart its count on a source change reports a false failure. It checks that the lock survives the removal of its trigger inputs and lasts until reset. It also checks that a status clear leaves a forced test failure standing. A design that released the lock early, or let the status write clear the test condition, would show a different readback or fail_o value.

// File: rtl/cfd_pkg.sv
package cfd_pkg;
  localparam logic [3:0] ADDR_KEY  = 4'h0;
  localparam logic [3:0] ADDR_STAT = 4'h1;
  localparam logic [3:0] ADDR_CTRL = 4'h2;
  localparam logic [7:0] UNLOCK_KEY = 8'hA5;
  localparam int unsigned WIN_CYC = 4;

  typedef enum logic [1:0] {
    SRC_MAIN = 2'd0,
    SRC_HF   = 2'd1,
    SRC_LF   = 2'd2,
    SRC_RSVD = 2'd3
  } src_e;

  typedef struct packed {
    src_e src;
    logic test;
    logic en;
  } ctrl_t;
endpackage

// File: rtl/cfd_monitor.sv
module cfd_monitor #(
  parameter int unsigned NSRC    = 3,
  parameter int unsigned TIMEOUT = 64,
  parameter int unsigned SW      = 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [NSRC-1:0] mclk_i,
  input  logic [SW-1:0]   sel_i,
  input  logic            en_i,
  output logic            det_o
);
  localparam int unsigned CW = $clog2(TIMEOUT + 1);

  logic [NSRC-1:0] s1_q, s2_q, s3_q, rise;
  logic [SW-1:0]   sel_d_q;
  logic            en_d_q;
  logic [CW-1:0]   cnt_q;
  logic            edge_sel, restart;

  for (genvar i = 0; i < NSRC; i++) begin : g_sync
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        s1_q[i] <= 1'b0;
        s2_q[i] <= 1'b0;
        s3_q[i] <= 1'b0;
      end else begin
        s1_q[i] <= mclk_i[i];
        s2_q[i] <= s1_q[i];
        s3_q[i] <= s2_q[i];
      end
    end
    assign rise[i] = s2_q[i] & ~s3_q[i];
  end

  assign edge_sel = (int'(sel_i) < NSRC) ? rise[sel_i] : 1'b0;
  assign restart  = (sel_i != sel_d_q) | (en_i & ~en_d_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_d_q <= '0;
      en_d_q  <= 1'b0;
      cnt_q   <= '0;
    end else begin
      sel_d_q <= sel_i;
      en_d_q  <= en_i;
      if (!en_i || edge_sel || restart) cnt_q <= '0;
      else if (cnt_q != CW'(TIMEOUT))   cnt_q <= cnt_q + 1'b1;
    end
  end

  assign det_o = en_i & (cnt_q == CW'(TIMEOUT));

  AST_CNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CW'(TIMEOUT)); // R5
  AST_RESTART_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i != sel_d_q) |=> cnt_q == '0); // R11
endmodule

// File: rtl/cfd_regs.sv
module cfd_regs
  import cfd_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       we_i,
  input  logic [3:0] addr_i,
  input  logic [7:0] wdata_i,
  output logic [7:0] rdata_o,
  input  logic       fail_int_en_i,
  input  logic       int_type_i,
  input  logic       det_i,
  output ctrl_t      ctrl_o,
  output logic       fail_o
);
  localparam int unsigned WW = $clog2(WIN_CYC + 1);

  ctrl_t         ctrl_q;
  logic [WW-1:0] win_q;
  logic          locked_q, lock_now, flag_q;
  logic          key_wr, ctrl_wr, ctrl_ok, stat_clr;

  assign key_wr   = we_i && addr_i == ADDR_KEY && wdata_i == UNLOCK_KEY;
  assign ctrl_wr  = we_i && addr_i == ADDR_CTRL;
  assign ctrl_ok  = ctrl_wr && win_q != '0;
  assign stat_clr = we_i && addr_i == ADDR_STAT && wdata_i[0];
  assign lock_now = locked_q | (ctrl_q.en & fail_int_en_i & int_type_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              win_q <= '0;
    else if (key_wr)          win_q <= WW'(WIN_CYC);
    else if (ctrl_wr)         win_q <= '0;
    else if (win_q != '0)     win_q <= win_q - 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q   <= '0;
      locked_q <= 1'b0;
    end else begin
      locked_q <= lock_now;
      if (ctrl_ok) begin
        ctrl_q.test <= wdata_i[1];
        if (!lock_now) begin
          ctrl_q.en <= wdata_i[0];
          if (wdata_i[3:2] != SRC_RSVD) ctrl_q.src <= src_e'(wdata_i[3:2]);
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       flag_q <= 1'b0;
    else if (det_i)    flag_q <= 1'b1;
    else if (stat_clr) flag_q <= 1'b0;
  end

  assign fail_o = flag_q | ctrl_q.test;
  assign ctrl_o = ctrl_q;

  always_comb begin
    case (addr_i)
      ADDR_CTRL: rdata_o = {4'b0, ctrl_q};
      ADDR_STAT: rdata_o = {7'b0, fail_o};
      default:   rdata_o = 8'h00;
    endcase
  end

  AST_CTRL_GUARD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_wr && win_q == '0) |=> $stable(ctrl_q)); // R2
  AST_SRC_LEGAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_q.src != SRC_RSVD); // R3
  AST_LOCK_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    locked_q |=> locked_q); // R10
  AST_LOCKED_FIELDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lock_now && ctrl_wr) |=> $stable(ctrl_q.src) && $stable(ctrl_q.en)); // R10
  AST_FLAG_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_q && !stat_clr) |=> flag_q); // R8
  AST_FLAG_NEEDS_EN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flag_q) |-> $past(ctrl_q.en)); // R6
endmodule

// File: rtl/cfd_ctrl.sv
module cfd_ctrl
  import cfd_pkg::*;
#(
  parameter int unsigned TIMEOUT = 64,
  parameter int unsigned NSRC    = 3
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            we_i,
  input  logic [3:0]      addr_i,
  input  logic [7:0]      wdata_i,
  output logic [7:0]      rdata_o,
  input  logic [NSRC-1:0] mclk_i,
  input  logic            fail_int_en_i,
  input  logic            int_type_i,
  output logic            fail_o,
  output logic            irq_o,
  output logic            nmi_o
);
  ctrl_t ctrl;
  logic  det;

  cfd_regs u_regs (
    .clk_i, .rst_ni, .we_i, .addr_i, .wdata_i, .rdata_o,
    .fail_int_en_i, .int_type_i,
    .det_i  (det),
    .ctrl_o (ctrl),
    .fail_o (fail_o)
  );

  cfd_monitor #(.NSRC(NSRC), .TIMEOUT(TIMEOUT), .SW(2)) u_mon (
    .clk_i, .rst_ni,
    .mclk_i (mclk_i),
    .sel_i  (ctrl.src),
    .en_i   (ctrl.en),
    .det_o  (det)
  );

  assign irq_o = fail_o & fail_int_en_i & ~int_type_i;
  assign nmi_o = fail_o & fail_int_en_i &  int_type_i;

  AST_IRQ_NMI_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(irq_o && nmi_o)); // R9
endmodule

// File: tb/cfd_ctrl_test.sv
module cfd_ctrl_test;
  logic       clk = 0, rst_n = 0, we = 0;
  logic [3:0] addr = 0;
  logic [7:0] wdata = 0, rdata;
  logic [2:0] mclk = 0, run = 3'b001;
  logic       int_en = 0, int_type = 0;
  logic       fail, irq, nmi;
  int         nchk = 0, nbad = 0, ph = 0;
  logic [7:0] v;

  always #5 clk = ~clk;

  always @(negedge clk) begin
    ph <= ph + 1;
    if (ph % 8 == 7) mclk <= mclk ^ run;
  end

  cfd_ctrl uut (
    .clk_i(clk), .rst_ni(rst_n), .we_i(we), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .mclk_i(mclk), .fail_int_en_i(int_en), .int_type_i(int_type),
    .fail_o(fail), .irq_o(irq), .nmi_o(nmi)
  );

  task automatic chk(string req, int act, int exp);
    nchk++;
    if (act != exp) begin
      nbad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [3:0] a, logic [7:0] d);
    we = 1; addr = a; wdata = d;
    @(negedge clk);
    we = 0; addr = 0; wdata = 0;
  endtask

  task automatic rd(logic [3:0] a, output logic [7:0] d);
    addr = a; #1; d = rdata; addr = 0;
  endtask

  task automatic pwr(logic [7:0] d);
    wr(4'h0, 8'hA5);
    wr(4'h2, d);
  endtask

  task automatic do_reset;
    rst_n = 0; idle(3); rst_n = 1; idle(1);
  endtask

  task automatic t_reset;
    rd(4'h2, v); chk("R1 ctrl", v, 8'h00);
    chk("R1 fail", fail, 0); chk("R1 irq", irq, 0); chk("R1 nmi", nmi, 0);
  endtask

  task automatic t_protect;
    wr(4'h2, 8'h01); rd(4'h2, v); chk("R2 no key", v, 8'h00);
    wr(4'h0, 8'hA5); idle(3); wr(4'h2, 8'h01);
    rd(4'h2, v); chk("R2 fourth cycle", v, 8'h01);
    wr(4'h2, 8'h00); rd(4'h2, v); chk("R2 window closed", v, 8'h01);
    wr(4'h0, 8'hA5); idle(4); wr(4'h2, 8'h00);
    rd(4'h2, v); chk("R2 fifth cycle", v, 8'h01);
    pwr(8'h00); rd(4'h2, v); chk("R2 back to back", v, 8'h00);
  endtask

  task automatic t_layout;
    pwr(8'hF4); rd(4'h2, v); chk("R3 upper bits", v, 8'h04);
    pwr(8'h0C); rd(4'h2, v); chk("R3 reserved src", v, 8'h04);
    pwr(8'h08); rd(4'h2, v); chk("R4 src 32k", v, 8'h08);
    pwr(8'h00); rd(4'h2, v); chk("R4 clear", v, 8'h00);
  endtask

  task automatic t_monitor;
    run = 3'b001; pwr(8'h01); idle(200); chk("R5 running clock", fail, 0);
    run = 3'b000; idle(40); chk("R5 inside timeout", fail, 0);
    idle(50); chk("R5 stopped clock", fail, 1);
    rd(4'h1, v); chk("R8 status read", v, 8'h01);
    run = 3'b001; idle(40); chk("R8 sticky", fail, 1);
    wr(4'h1, 8'h01); idle(1); chk("R8 cleared", fail, 0);
  endtask

  task automatic t_disabled;
    pwr(8'h00); run = 3'b000; idle(150); chk("R6 disabled", fail, 0);
    run = 3'b001; idle(20);
  endtask

  task automatic t_restart;
    run = 3'b001; pwr(8'h05); idle(40); chk("R11 before switch", fail, 0);
    pwr(8'h09); idle(40); chk("R11 restarted", fail, 0);
    idle(40); chk("R11 after switch timeout", fail, 1);
    pwr(8'h01); idle(40); wr(4'h1, 8'h01); idle(1);
    chk("R8 clear after recovery", fail, 0);
  endtask

  task automatic t_test_bit;
    pwr(8'h03); idle(1); chk("R7 forced", fail, 1);
    wr(4'h1, 8'h01); idle(1); chk("R7 status clear keeps", fail, 1);
    pwr(8'h01); idle(1); chk("R7 test cleared", fail, 0);
  endtask

  task automatic t_irq_lock;
    int_en = 1; int_type = 0; pwr(8'h03); idle(1);
    chk("R9 irq", irq, 1); chk("R9 nmi low", nmi, 0);
    int_en = 0; idle(1); chk("R9 masked", irq | nmi, 0);
    int_en = 1; int_type = 1; idle(2);
    chk("R9 nmi", nmi, 1); chk("R9 irq low", irq, 0);
    pwr(8'h01);
    int_en = 0; int_type = 0; idle(2);
    pwr(8'h08); rd(4'h2, v); chk("R10 locked fields", v, 8'h01);
    pwr(8'h0A); rd(4'h2, v); chk("R10 test writable", v, 8'h03);
    pwr(8'h00); rd(4'h2, v); chk("R10 en kept", v, 8'h01);
    do_reset; rd(4'h2, v); chk("R10 reset clears", v, 8'h00);
    pwr(8'h08); rd(4'h2, v); chk("R10 unlocked", v, 8'h08);
  endtask

  initial begin
    do_reset;
    t_reset;
    t_protect;
    t_layout;
    t_monitor;
    t_disabled;
    t_restart;
    t_test_bit;
    t_irq_lock;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    nchk++; nbad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
    $finish;
  end
endmodule